// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time as six packed-BCD bytes: seconds, minutes, hours, day of month, month and a two-digit year counted from 2000. Time moves forward once per second. The one-second step comes from a prescaler that counts pulses of a slow reference tick (`ref_tick`, one clock wide, nominally 128 per second). Month lengths follow the calendar, and February gets a 29th day in years divisible by four. Software reads and writes every field through a byte-wide register port. A read is combinational. A write is accepted in the cycle it is presented. The port has no back-pressure and carries no data stream, so no valid/ready handshake is involved.

Two interrupt sources share one pending register. The alarm compares the running time against six stored alarm bytes. Only the fields whose own match bit is set take part, and a separate global bit gates the whole comparison. The periodic tick counts reference pulses and raises its pending flag every N+1 pulses, where N is a programmable reload value. Each pending flag drives its own interrupt pin, and software clears a flag by writing 1 to it.

Register map (4-bit address): 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 alarm control, 8 to 13 alarm seconds/minutes/hours/day/month/year, 14 tick, 15 pending.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time reads 00 s, 00 min, 00 h, day 01, month 01, year 00. The control, alarm control, tick and pending registers read 0x00, and both interrupt pins are low.
- R2: Every register at addresses 0 to 14 reads back the value last written, except where R9 or R10 state otherwise. Control keeps bits 2:0 only, and its other bits read 0.
- R3: Control bit 0 (run) set, with bits 1 and 2 clear, advances the seconds by one on every 128th `ref_tick` (`TICKS_PER_SEC`). With run clear, time does not change.
- R4: A write to a time field (addresses 1 to 6) is visible on the next clock edge. It also restarts the prescaler, so the next increment needs a full `TICKS_PER_SEC` reference pulses.
- R5: On each one-second step, seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00 and carry into the day. All counting is in BCD (09 is followed by 10).
- R6: The day rolls to 01 after the last day of the month: 30 days for months 04, 06, 09 and 11, 28 for February (29 when the year is divisible by 4, including 00), and 31 for the rest. Month 12 rolls to 01 and increments the year, and year 99 wraps to 00.
- R7: Control bit 1 (fast count) makes the seconds advance on every `ref_tick` while run is set. Control bit 2 (divider hold) stops all advancing and holds the prescaler at zero, whatever the other bits are.
- R8: Alarm control bit 7 is the global enable. Bits 0 to 5 enable matching of seconds, minutes, hours, day, month and year. The alarm pending flag (pending bit 0) is set one clock after the time starts to equal every enabled field. Fields whose match bit is clear are ignored, and with no field enabled the alarm never fires.
- R9: Clearing the global alarm bit stops the alarm without altering the per-field match bits or the alarm field values. Setting it again resumes matching.
- R10: The tick register holds an enable in bit 7 and the reload N in bits 6:0, both readable. With the enable set, tick pending (pending bit 1) is set on the (N+1)th `ref_tick` counted from the last tick-register write, and then every N+1 pulses. With it clear, nothing is counted.
- R11: Writing 1 to a pending bit clears it, and writing 0 has no effect. A set in the same cycle overrides the clear. `alarm_irq` and `tick_irq` show pending bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse of the slow reference tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Alarm pending flag |
| tick_irq | output | 1 | Tick pending flag |

## Verification
A wrong prescaler count shows at the seconds register within a single second. It appears either as an early step or as a missing restart after a time write. A wrong carry or month-length decision stays hidden until the exact rollover instant, so the bench loads times one second before each boundary and reads all affected fields right after the step. A stale match history or pending state shows on the interrupt pins one clock after the matching second or the counted tick. Clear-versus-set ordering is exposed by writing a clear in the same cycle as a tick.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 8;
  localparam int NFIELD = 6;

  localparam logic [REG_AW-1:0] A_CTRL     = 4'd0;
  localparam logic [REG_AW-1:0] A_SEC      = 4'd1;
  localparam logic [REG_AW-1:0] A_MIN      = 4'd2;
  localparam logic [REG_AW-1:0] A_HOUR     = 4'd3;
  localparam logic [REG_AW-1:0] A_DAY      = 4'd4;
  localparam logic [REG_AW-1:0] A_MON      = 4'd5;
  localparam logic [REG_AW-1:0] A_YEAR     = 4'd6;
  localparam logic [REG_AW-1:0] A_ALM_CTRL = 4'd7;
  localparam logic [REG_AW-1:0] A_ALM_BASE = 4'd8;
  localparam logic [REG_AW-1:0] A_TICK     = 4'd14;
  localparam logic [REG_AW-1:0] A_PEND     = 4'd15;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_FAST = 1;
  localparam int CTRL_HOLD = 2;
  localparam int CTRL_W    = 3;
  localparam int ALM_GLOBAL = 7;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by 4 in BCD: even tens need units 0/4/8, odd tens need 2/6
  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_second_gen.sv
`timescale 1ns/1ps
module rtc_second_gen #(
  parameter int TICKS_PER_SEC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic run,
  input  logic fast,
  input  logic hold,
  input  logic restart,
  output logic sec_pulse
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] psc_q;
  logic          active;

  assign active    = run && !hold;
  assign sec_pulse = active && ref_tick && !restart && (fast || (psc_q == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   psc_q <= '0;
    else if (restart || hold)     psc_q <= '0;
    else if (run && !fast && ref_tick)
      psc_q <= (psc_q == LAST) ? '0 : psc_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_pulse,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [REG_DW-1:0]    wr_data,
  output rtc_time_t            now
);
  localparam rtc_time_t RESET_TIME = '{year: 8'h00, mon: 8'h01, day: 8'h01,
                                       hour: 8'h00, min: 8'h00, sec: 8'h00};
  rtc_time_t t_q, t_adv;

  always_comb begin
    t_adv = t_q;
    if (t_q.sec >= 8'h59) begin
      t_adv.sec = 8'h00;
      if (t_q.min >= 8'h59) begin
        t_adv.min = 8'h00;
        if (t_q.hour >= 8'h23) begin
          t_adv.hour = 8'h00;
          if (t_q.day >= last_day(t_q.mon, t_q.year)) begin
            t_adv.day = 8'h01;
            if (t_q.mon >= 8'h12) begin
              t_adv.mon  = 8'h01;
              t_adv.year = (t_q.year >= 8'h99) ? 8'h00 : bcd_inc(t_q.year);
            end else begin
              t_adv.mon = bcd_inc(t_q.mon);
            end
          end else begin
            t_adv.day = bcd_inc(t_q.day);
          end
        end else begin
          t_adv.hour = bcd_inc(t_q.hour);
        end
      end else begin
        t_adv.min = bcd_inc(t_q.min);
      end
    end else begin
      t_adv.sec = bcd_inc(t_q.sec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= RESET_TIME;
    else if (wr_en) begin
      case (wr_addr)
        A_SEC:   t_q.sec  <= wr_data;
        A_MIN:   t_q.min  <= wr_data;
        A_HOUR:  t_q.hour <= wr_data;
        A_DAY:   t_q.day  <= wr_data;
        A_MON:   t_q.mon  <= wr_data;
        A_YEAR:  t_q.year <= wr_data;
        default: t_q <= t_q;
      endcase
    end else if (sec_pulse) begin
      t_q <= t_adv;
    end
  end

  assign now = t_q;
endmodule

// File: rtl/rtc_alarm.sv
`timescale 1ns/1ps
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [REG_AW-1:0]             wr_addr,
  input  logic [REG_DW-1:0]             wr_data,
  input  logic [NFIELD-1:0][7:0]        now_f,
  input  logic                          clr,
  output logic [REG_DW-1:0]             ctl,
  output logic [NFIELD-1:0][7:0]        val,
  output logic                          hit,
  output logic                          pend
);
  logic [REG_DW-1:0]      ctl_q;
  logic [NFIELD-1:0][7:0] val_q;
  logic [NFIELD-1:0]      fld_ok;
  logic                   match, match_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      val_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_ALM_CTRL) ctl_q <= wr_data;
      for (int i = 0; i < NFIELD; i++)
        if (wr_addr == A_ALM_BASE + REG_AW'(i)) val_q[i] <= wr_data;
    end
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    assign fld_ok[g] = !ctl_q[g] || (val_q[g] == now_f[g]);
  end

  assign match = ctl_q[ALM_GLOBAL] && (|ctl_q[NFIELD-1:0]) && (&fld_ok);
  assign hit   = match && !match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      match_q <= match;
      if (hit)      pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
    end
  end

  assign ctl  = ctl_q;
  assign val  = val_q;
  assign pend = pend_q;
endmodule

// File: rtl/rtc_tick_gen.sv
`timescale 1ns/1ps
module rtc_tick_gen #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             clr,
  output logic [CFG_W-1:0] cfg,
  output logic             hit,
  output logic             pend
);
  localparam int RW = CFG_W - 1;

  logic [CFG_W-1:0] cfg_q;
  logic [RW-1:0]    cnt_q;
  logic             en, pend_q;

  assign en  = cfg_q[CFG_W-1];
  assign hit = en && ref_tick && !wr_en && (cnt_q == cfg_q[RW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else if (wr_en) begin
      cfg_q <= wr_data;
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (ref_tick) begin
      cnt_q <= (cnt_q == cfg_q[RW-1:0]) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign cfg  = cfg_q;
  assign pend = pend_q;
endmodule

// File: rtl/bcd_calendar_rtc.sv
`timescale 1ns/1ps
module bcd_calendar_rtc
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              alarm_irq,
  output logic              tick_irq
);
  logic [CTRL_W-1:0]      ctrl_q;
  logic                   time_wr, sec_pulse;
  logic                   pend_wr, alm_clr, tick_clr;
  logic                   alm_hit, alm_pend, tick_hit, tick_pend;
  logic [REG_DW-1:0]      alm_ctl, tick_cfg;
  logic [NFIELD-1:0][7:0] alm_val, now_flat;
  rtc_time_t              now_time;

  assign time_wr  = reg_wr && (reg_addr >= A_SEC) && (reg_addr <= A_YEAR);
  assign pend_wr  = reg_wr && (reg_addr == A_PEND);
  assign alm_clr  = pend_wr && reg_wdata[0];
  assign tick_clr = pend_wr && reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctrl_q <= '0;
    else if (reg_wr && reg_addr == A_CTRL)   ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  rtc_second_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_secgen (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .run(ctrl_q[CTRL_RUN]), .fast(ctrl_q[CTRL_FAST]), .hold(ctrl_q[CTRL_HOLD]),
    .restart(time_wr), .sec_pulse(sec_pulse)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse),
    .wr_en(time_wr), .wr_addr(reg_addr), .wr_data(reg_wdata), .now(now_time)
  );

  assign now_flat = now_time;

  rtc_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .now_f(now_flat), .clr(alm_clr), .ctl(alm_ctl), .val(alm_val),
    .hit(alm_hit), .pend(alm_pend)
  );

  rtc_tick_gen #(.CFG_W(REG_DW)) u_tick (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .wr_en(reg_wr && reg_addr == A_TICK), .wr_data(reg_wdata), .clr(tick_clr),
    .cfg(tick_cfg), .hit(tick_hit), .pend(tick_pend)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:      reg_rdata = {{(REG_DW-CTRL_W){1'b0}}, ctrl_q};
      A_SEC:       reg_rdata = now_time.sec;
      A_MIN:       reg_rdata = now_time.min;
      A_HOUR:      reg_rdata = now_time.hour;
      A_DAY:       reg_rdata = now_time.day;
      A_MON:       reg_rdata = now_time.mon;
      A_YEAR:      reg_rdata = now_time.year;
      A_ALM_CTRL:  reg_rdata = alm_ctl;
      4'd8:        reg_rdata = alm_val[0];
      4'd9:        reg_rdata = alm_val[1];
      4'd10:       reg_rdata = alm_val[2];
      4'd11:       reg_rdata = alm_val[3];
      4'd12:       reg_rdata = alm_val[4];
      4'd13:       reg_rdata = alm_val[5];
      A_TICK:      reg_rdata = tick_cfg;
      A_PEND:      reg_rdata = {{(REG_DW-2){1'b0}}, tick_pend, alm_pend};
      default:     reg_rdata = '0;
    endcase
  end

  assign alarm_irq = alm_pend;
  assign tick_irq  = tick_pend;
endmodule

// File: rtl/rtc_checker.sv
`timescale 1ns/1ps
module rtc_checker
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic              alarm_irq,
  input logic              tick_irq,
  input logic              sec_pulse,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [REG_DW-1:0] alm_ctl,
  input logic              alm_hit,
  input rtc_time_t         now_time
);
  assert_sec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !(reg_wr && reg_addr == A_SEC)) |=> $stable(now_time.sec));

  assert_sec_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && now_time.sec == 8'h59) |=> (now_time.sec == 8'h00));

  assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CTRL_HOLD] |-> !sec_pulse);

  assert_alarm_needs_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(alm_ctl[ALM_GLOBAL]));

  assert_tick_needs_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_irq) |-> $past(ref_tick));

  assert_pend_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PEND && reg_wdata[0] && !alm_hit) |=> !alarm_irq);
endmodule

bind bcd_calendar_rtc rtc_checker u_checker (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .alarm_irq(alarm_irq),
  .tick_irq(tick_irq), .sec_pulse(sec_pulse), .ctrl_q(ctrl_q),
  .alm_ctl(alm_ctl), .alm_hit(alm_hit), .now_time(now_time)
);

// File: tb/test_bcd_calendar_rtc.sv
`timescale 1ns/1ps
module test_bcd_calendar_rtc;
  localparam int TPS = 128;
  localparam logic [4:0] CTRL = 5'd0, SEC = 5'd1, MIN = 5'd2, HOUR = 5'd3,
                         DAY = 5'd4, MON = 5'd5, YEAR = 5'd6, ALMC = 5'd7,
                         ASEC = 5'd8, AMIN = 5'd9, AHOUR = 5'd10, ADAY = 5'd11,
                         TICK = 5'd14, PEND = 5'd15, IRQ = 5'd16;

  logic       clk = 1'b0;
  logic       rst_n, ref_tick, reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       alarm_irq, tick_irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  typedef struct { logic [4:0] addr; logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  event  look;

  always #5 clk = ~clk;

  bcd_calendar_rtc #(.TICKS_PER_SEC(TPS)) i_bcd_calendar_rtc (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_irq(alarm_irq), .tick_irq(tick_irq)
  );

  // monitor: pops expectations and compares against the ports
  initial forever begin
    @(look);
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.addr[4] ? {6'b0, tick_irq, alarm_irq} : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: addr %0d got %02h expected %02h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic chk(input logic [4:0] a, input logic [7:0] e, input string tag);
    item_t it;
    reg_addr = a[3:0];
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> look;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1;
      @(negedge clk);
    end
    ref_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    wr(YEAR, y); wr(MON, mo); wr(DAY, d); wr(HOUR, h); wr(MIN, mi); wr(SEC, s);
  endtask

  task automatic step_date(input logic [7:0] y, mo, d,
                           input logic [7:0] ey, emo, ed, input string tag);
    set_time(y, mo, d, 8'h23, 8'h59, 8'h59);
    pulse(TPS);
    chk(DAY, ed, tag); chk(MON, emo, tag); chk(YEAR, ey, tag); chk(HOUR, 8'h00, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(SEC, 8'h00, "R1 sec");   chk(MIN, 8'h00, "R1 min");  chk(HOUR, 8'h00, "R1 hour");
    chk(DAY, 8'h01, "R1 day");   chk(MON, 8'h01, "R1 mon");  chk(YEAR, 8'h00, "R1 year");
    chk(CTRL, 8'h00, "R1 ctrl"); chk(ALMC, 8'h00, "R1 almc"); chk(TICK, 8'h00, "R1 tick");
    chk(PEND, 8'h00, "R1 pend"); chk(IRQ, 8'h00, "R1 irq pins");

    // R3 stopped, then one second
    pulse(200);
    chk(SEC, 8'h00, "R3 stopped clock");
    wr(CTRL, 8'hF9);
    chk(CTRL, 8'h01, "R2 ctrl keeps low bits");
    pulse(TPS - 1); chk(SEC, 8'h00, "R3 before full second");
    pulse(1);       chk(SEC, 8'h01, "R3 one second");

    // R4 write restarts prescaler
    pulse(60);
    wr(SEC, 8'h30);        chk(SEC, 8'h30, "R4 write visible");
    pulse(TPS - 1);        chk(SEC, 8'h30, "R4 prescaler restarted");
    pulse(1);              chk(SEC, 8'h31, "R4 full second after write");

    // R5 carries
    set_time(8'h00, 8'h06, 8'h15, 8'h23, 8'h59, 8'h59);
    pulse(TPS);
    chk(SEC, 8'h00, "R5 sec wrap"); chk(MIN, 8'h00, "R5 min wrap");
    chk(HOUR, 8'h00, "R5 hour wrap"); chk(DAY, 8'h16, "R5 day carry");
    set_time(8'h00, 8'h06, 8'h15, 8'h09, 8'h59, 8'h59);
    pulse(TPS);
    chk(HOUR, 8'h10, "R5 BCD hour 09 to 10"); chk(DAY, 8'h15, "R5 day unchanged");

    // R6 month lengths and years
    step_date(8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29, "R6 leap feb 28");
    step_date(8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01, "R6 leap feb 29");
    step_date(8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01, "R6 common feb");
    step_date(8'h00, 8'h02, 8'h28, 8'h00, 8'h02, 8'h29, "R6 year 00 leap");
    step_date(8'h24, 8'h04, 8'h30, 8'h24, 8'h05, 8'h01, "R6 april");
    step_date(8'h24, 8'h05, 8'h30, 8'h24, 8'h05, 8'h31, "R6 may 30");
    step_date(8'h12, 8'h09, 8'h30, 8'h12, 8'h10, 8'h01, "R6 sept to oct");
    step_date(8'h19, 8'h12, 8'h31, 8'h20, 8'h01, 8'h01, "R6 new year BCD");
    step_date(8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01, "R6 year wrap");

    // R7 fast count and divider hold
    wr(CTRL, 8'h03); wr(SEC, 8'h10);
    pulse(5);  chk(SEC, 8'h15, "R7 fast count");
    wr(CTRL, 8'h05); chk(CTRL, 8'h05, "R2 ctrl readback");
    pulse(300); chk(SEC, 8'h15, "R7 hold stops");
    wr(CTRL, 8'h07);
    pulse(10); chk(SEC, 8'h15, "R7 hold beats fast");
    wr(CTRL, 8'h01);
    pulse(TPS - 1); chk(SEC, 8'h15, "R7 prescaler held at zero");
    pulse(1);       chk(SEC, 8'h16, "R7 resume");

    // R8 alarm
    wr(CTRL, 8'h03);
    wr(ASEC, 8'h05); wr(AMIN, 8'h00); wr(AHOUR, 8'h07); wr(ADAY, 8'h01);
    wr(ALMC, 8'h83);
    chk(ALMC, 8'h83, "R2 alarm ctrl readback"); chk(AHOUR, 8'h07, "R2 alarm hour readback");
    set_time(8'h00, 8'h01, 8'h01, 8'h12, 8'h00, 8'h00);
    pulse(4); idle(1); chk(IRQ, 8'h00, "R8 before match");
    pulse(1); idle(1);
    chk(SEC, 8'h05, "R8 at match second");
    chk(IRQ, 8'h01, "R8 fires, disabled hour ignored");
    chk(PEND, 8'h01, "R8 pending bit 0");

    // R11 pending clear rules
    wr(PEND, 8'h00); chk(IRQ, 8'h01, "R11 write 0 no effect");
    wr(PEND, 8'h01); chk(IRQ, 8'h00, "R11 write 1 clears");

    wr(ALMC, 8'h87);
    set_time(8'h00, 8'h01, 8'h01, 8'h12, 8'h00, 8'h00);
    pulse(10); idle(1); chk(IRQ, 8'h00, "R8 enabled hour mismatch blocks");
    wr(AHOUR, 8'h12); wr(ALMC, 8'h80);
    set_time(8'h00, 8'h01, 8'h01, 8'h12, 8'h00, 8'h00);
    pulse(10); idle(1); chk(IRQ, 8'h00, "R8 no field enabled never fires");

    // R9 global enable off keeps fields
    wr(ALMC, 8'h03);
    set_time(8'h00, 8'h01, 8'h01, 8'h12, 8'h00, 8'h00);
    pulse(10); idle(1); chk(IRQ, 8'h00, "R9 global off");
    chk(ALMC, 8'h03, "R9 field enables kept"); chk(ASEC, 8'h05, "R9 alarm sec kept");
    wr(ALMC, 8'h83);
    set_time(8'h00, 8'h01, 8'h01, 8'h12, 8'h00, 8'h00);
    pulse(5); idle(1); chk(IRQ, 8'h01, "R9 re-enabled fires");
    wr(PEND, 8'h01); wr(ALMC, 8'h00); wr(CTRL, 8'h00);

    // R10 periodic tick
    wr(TICK, 8'h83); chk(TICK, 8'h83, "R10 tick readback");
    pulse(3); chk(IRQ, 8'h00, "R10 before N+1");
    pulse(1); chk(IRQ, 8'h02, "R10 at N+1"); chk(PEND, 8'h02, "R10 pending bit 1");
    wr(PEND, 8'h02); chk(IRQ, 8'h00, "R11 tick clear");
    pulse(3); chk(IRQ, 8'h00, "R10 second period early");
    pulse(1); chk(IRQ, 8'h02, "R10 second period");
    wr(PEND, 8'h02);
    wr(TICK, 8'h03); chk(TICK, 8'h03, "R10 enable cleared, reload kept");
    pulse(20); chk(IRQ, 8'h00, "R10 disabled");
    wr(TICK, 8'h80);
    pulse(1); chk(IRQ, 8'h02, "R10 N=0 every pulse");

    // R11 set beats clear
    ref_tick = 1'b1;
    wr(PEND, 8'h02);
    ref_tick = 1'b0;
    chk(IRQ, 8'h02, "R11 set wins over clear");
    wr(PEND, 8'h02); chk(IRQ, 8'h00, "R11 clear after");
    wr(TICK, 8'h00);

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule